// File: doc/BRIEF.md
# Pixel Pack and Format Unit

This block is a SIMD formatting datapath for pixel processing. It accepts two 64-bit operands and a 3-bit operation code. It turns wide fixed-point lanes into saturated bytes or saturated 16-bit words. It can also widen bytes into 16-bit lanes or interleave the bytes of two words. The result is registered, so it appears one cycle after the request, together with a valid flag.

The pack operations use a shift amount taken from a small scale register. Software-side logic loads that register through a dedicated write port. Each operation applies its own scale width, its own binary-point position and its own saturation range. All intermediate values are kept 64 bits wide, so a large scale saturates the result instead of wrapping it. One pack mode also shifts the first operand up by a byte. This lets successive packs build up a pixel word.

Top module: `pxf_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `result` is 0 and the scale register holds 0.
- R2: When `in_valid` is 1 at a clock edge, `out_valid` is 1 after that edge and `result` holds the outcome for the operands sampled at that edge. When `in_valid` is 0, `out_valid` is 0 after the edge and `result` keeps its previous value.
- R3: When `scale_we` is 1 at an edge, the scale register takes `scale_wdata` at that edge. An operation sampled at the same edge still uses the old scale.
- R4: Op code 0 (16-bit pack) applies only bits 3:0 of the scale. Each signed 16-bit lane i of `opb` is shifted left by that amount, then arithmetically right by 7, then clamped to 0..255. The value goes into byte i of the result.
- R5: Op code 1 (32-bit accumulate pack) starts from `opa` shifted left by 8, with bytes 0 and 4 cleared. Each signed 32-bit lane i of `opb` is shifted left by the full 5-bit scale, then arithmetically right by 23, then clamped to 0..255. The value is ORed into byte 4*i.
- R6: Op code 2 (fixed-point pack) shifts each signed 32-bit lane i of `opb` left by the full scale, then arithmetically right by 16. It clamps the value to -32768..32767 and places it in result bits 16*i+15:16*i.
- R7: Op code 3 (expand) takes byte i of `opb[31:0]`, shifts it left by 4 and zero-extends it into 16-bit lane i. The low and high nibble of every lane are therefore 0.
- R8: Op code 4 (merge) places byte i of `opb[31:0]` in result byte 2*i and byte i of `opa[31:0]` in result byte 2*i+1.
- R9: Op codes 5, 6 and 7 give a result of 0, with `out_valid` still asserted.
- R10: For op codes 0 and 2, result bits 63:32 are 0. Bits of the operands outside those an operation reads have no effect.
- R11: Scaling never wraps. A lane whose scaled value exceeds the clamp range gives the nearest range limit, even at the maximum scale of 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_we | input | 1 | Load enable for the scale register |
| scale_wdata | input | 5 | New scale value |
| in_valid | input | 1 | Operation request |
| op | input | 3 | Operation code (0..4 defined) |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 64 | Registered formatted result |

## Verification
The bench builds the unit with its default parameters: 64-bit operands, a 5-bit scale and binary points at 7, 23 and 16. At these settings the maximum scale of 31 drives a 32-bit lane far beyond 32 bits, so the saturation limits at both ends of the fixed-point range can be reached. Scale values above 15 show that the 16-bit pack ignores the upper scale bit. A write to the scale register in the same cycle as a request shows which scale value that request uses.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
    localparam int unsigned WIDE_W = 64;

    typedef enum logic [2:0] {
        OP_PACK16  = 3'd0,
        OP_PACK32  = 3'd1,
        OP_PACKFIX = 3'd2,
        OP_EXPAND  = 3'd3,
        OP_MERGE   = 3'd4
    } pxf_op_e;
endpackage

// File: rtl/pxf_clamp_lane.sv
module pxf_clamp_lane
    import pxf_pkg::*;
#(
    parameter int unsigned IN_W       = 16,
    parameter int unsigned SH_W       = 4,
    parameter int unsigned FRAC       = 7,
    parameter int unsigned OUT_W      = 8,
    parameter bit          OUT_SIGNED = 1'b0
) (
    input  logic [IN_W-1:0]  lane_i,
    input  logic [SH_W-1:0]  shift_i,
    output logic [OUT_W-1:0] sat_o
);
    localparam logic signed [WIDE_W-1:0] ONE    = WIDE_W'(1);
    localparam logic signed [WIDE_W-1:0] HI_LIM = OUT_SIGNED ? (ONE <<< (OUT_W-1)) - ONE
                                                             : (ONE <<< OUT_W) - ONE;
    localparam logic signed [WIDE_W-1:0] LO_LIM = OUT_SIGNED ? -(ONE <<< (OUT_W-1))
                                                             : '0;

    logic signed [WIDE_W-1:0] ext_v;
    logic signed [WIDE_W-1:0] shl_v;
    logic signed [WIDE_W-1:0] pt_v;

    always_comb begin
        ext_v = {{(WIDE_W-IN_W){lane_i[IN_W-1]}}, lane_i};
        shl_v = ext_v <<< shift_i;
        pt_v  = shl_v >>> FRAC;
        if (pt_v > HI_LIM)
            sat_o = HI_LIM[OUT_W-1:0];
        else if (pt_v < LO_LIM)
            sat_o = LO_LIM[OUT_W-1:0];
        else
            sat_o = pt_v[OUT_W-1:0];
    end
endmodule

// File: rtl/pxf_scale_reg.sv
module pxf_scale_reg #(
    parameter int unsigned SCALE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [SCALE_W-1:0] wdata_i,
    output logic [SCALE_W-1:0] scale_o
);
    logic [SCALE_W-1:0] scale_d, scale_q;

    always_comb begin
        scale_d = scale_q;
        if (we_i)
            scale_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            scale_q <= '0;
        else
            scale_q <= scale_d;
    end

    assign scale_o = scale_q;

    // R3
    scale_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> scale_o == $past(wdata_i));

    // R3
    scale_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(scale_o));
endmodule

// File: rtl/pxf_datapath.sv
module pxf_datapath
    import pxf_pkg::*;
#(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned SCALE_W  = 5,
    parameter int unsigned NARROW_W = 4,
    parameter int unsigned P16_FRAC = 7,
    parameter int unsigned P32_FRAC = 23,
    parameter int unsigned FIX_FRAC = 16
) (
    input  logic [2:0]         op_i,
    input  logic [DATA_W-1:0]  opa_i,
    input  logic [DATA_W-1:0]  opb_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [DATA_W-1:0]  res_o
);
    localparam int unsigned HALF_W  = DATA_W / 2;
    localparam int unsigned H_LANES = DATA_W / 16;
    localparam int unsigned W_LANES = DATA_W / 32;
    localparam int unsigned N_BYTES = HALF_W / 8;

    logic [8*H_LANES-1:0]  p16_pack;
    logic [8*W_LANES-1:0]  p32_bytes;
    logic [16*W_LANES-1:0] fix_pack;
    logic [DATA_W-1:0]     exp_res;
    logic [DATA_W-1:0]     mrg_res;
    logic [DATA_W-1:0]     p32_res;

    for (genvar g = 0; g < H_LANES; g++) begin : g_p16
        pxf_clamp_lane #(
            .IN_W(16), .SH_W(NARROW_W), .FRAC(P16_FRAC), .OUT_W(8), .OUT_SIGNED(1'b0)
        ) u_lane (
            .lane_i (opb_i[16*g +: 16]),
            .shift_i(scale_i[NARROW_W-1:0]),
            .sat_o  (p16_pack[8*g +: 8])
        );
    end

    for (genvar g = 0; g < W_LANES; g++) begin : g_wide
        pxf_clamp_lane #(
            .IN_W(32), .SH_W(SCALE_W), .FRAC(P32_FRAC), .OUT_W(8), .OUT_SIGNED(1'b0)
        ) u_p32 (
            .lane_i (opb_i[32*g +: 32]),
            .shift_i(scale_i),
            .sat_o  (p32_bytes[8*g +: 8])
        );
        pxf_clamp_lane #(
            .IN_W(32), .SH_W(SCALE_W), .FRAC(FIX_FRAC), .OUT_W(16), .OUT_SIGNED(1'b1)
        ) u_fix (
            .lane_i (opb_i[32*g +: 32]),
            .shift_i(scale_i),
            .sat_o  (fix_pack[16*g +: 16])
        );
    end

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        assign exp_res[16*g +: 16]    = {4'b0000, opb_i[8*g +: 8], 4'b0000};
        assign mrg_res[16*g +: 8]     = opb_i[8*g +: 8];
        assign mrg_res[16*g + 8 +: 8] = opa_i[8*g +: 8];
    end

    always_comb begin
        p32_res = opa_i << 8;
        for (int i = 0; i < W_LANES; i++) begin
            p32_res[32*i +: 8] = p32_bytes[8*i +: 8];
        end
    end

    always_comb begin
        res_o = '0;
        case (op_i)
            OP_PACK16:  res_o = {{(DATA_W-8*H_LANES){1'b0}}, p16_pack};
            OP_PACK32:  res_o = p32_res;
            OP_PACKFIX: res_o = {{(DATA_W-16*W_LANES){1'b0}}, fix_pack};
            OP_EXPAND:  res_o = exp_res;
            OP_MERGE:   res_o = mrg_res;
            default:    res_o = '0;
        endcase
    end
endmodule

// File: rtl/pxf_unit.sv
module pxf_unit
    import pxf_pkg::*;
#(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned SCALE_W  = 5,
    parameter int unsigned NARROW_W = 4,
    parameter int unsigned P16_FRAC = 7,
    parameter int unsigned P32_FRAC = 23,
    parameter int unsigned FIX_FRAC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scale_we,
    input  logic [SCALE_W-1:0] scale_wdata,
    input  logic               in_valid,
    input  logic [2:0]         op,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] EXP_ZERO_MASK = {(DATA_W/16){16'hF00F}};

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } out_st_t;

    out_st_t           st_d, st_q;
    logic [SCALE_W-1:0] scale_cur;
    logic [DATA_W-1:0]  dp_res;

    pxf_scale_reg #(.SCALE_W(SCALE_W)) u_scale (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (scale_we),
        .wdata_i(scale_wdata),
        .scale_o(scale_cur)
    );

    pxf_datapath #(
        .DATA_W(DATA_W), .SCALE_W(SCALE_W), .NARROW_W(NARROW_W),
        .P16_FRAC(P16_FRAC), .P32_FRAC(P32_FRAC), .FIX_FRAC(FIX_FRAC)
    ) u_dp (
        .op_i   (op),
        .opa_i  (opa),
        .opb_i  (opb),
        .scale_i(scale_cur),
        .res_o  (dp_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.res = dp_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R7
    expand_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_EXPAND) |=> (result & EXP_ZERO_MASK) == '0);

    // R10
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_PACK16 || op == OP_PACKFIX)) |=> result[DATA_W-1:HALF_W] == '0);

    // R9
    unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > OP_MERGE) |=> result == '0);
endmodule

// File: tb/test_pxf_unit.sv
module test_pxf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scale_we = 1'b0;
    logic [4:0]  scale_wdata = '0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pxf_unit i_pxf_unit (
        .clk(clk), .rst_n(rst_n), .scale_we(scale_we), .scale_wdata(scale_wdata),
        .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [4:0]  sc;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R4 scale 0, saturation high and low
        '{3'd0, 5'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0080_8000_7FFF_0100, 64'h0000_0000_0100_FF02, 8'd4},
        // R4 scale 3
        '{3'd0, 5'd3,  64'h0,                   64'hFFFF_0FFF_0100_0010, 64'h0000_0000_00FF_1001, 8'd4},
        // R4 scale 19 acts as 3
        '{3'd0, 5'd19, 64'h0,                   64'hFFFF_0FFF_0100_0010, 64'h0000_0000_00FF_1001, 8'd4},
        // R5 accumulate shift
        '{3'd1, 5'd0,  64'h1122_3344_5566_7788, 64'h7FFF_FFFF_0080_0000, 64'h2233_44FF_6677_8801, 8'd5},
        // R5 scale 8, negative lane
        '{3'd1, 5'd8,  64'h0,                   64'hFFF0_0000_0001_0000, 64'h0000_0000_0000_0002, 8'd5},
        // R6 scale 0
        '{3'd2, 5'd0,  64'h0,                   64'hFFFF_0000_0001_0000, 64'h0000_0000_FFFF_0001, 8'd6},
        // R11 max scale saturates both ends
        '{3'd2, 5'd31, 64'h0,                   64'h8000_0000_7FFF_FFFF, 64'h0000_0000_8000_7FFF, 8'd11},
        // R6 scale 4
        '{3'd2, 5'd4,  64'h0,                   64'hFFFF_F000_0001_2345, 64'h0000_0000_FFFF_0012, 8'd6},
        // R7 expand, upper half of opb ignored
        '{3'd3, 5'd0,  64'h0,                   64'hDEAD_BEEF_A1B2_C3D4, 64'h0A10_0B20_0C30_0D40, 8'd7},
        // R8 merge, upper halves ignored
        '{3'd4, 5'd0,  64'hCAFE_0000_4433_2211, 64'h1234_5678_8877_6655, 64'h4488_3377_2266_1155, 8'd8},
        // R9 unused op code
        '{3'd5, 5'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   8'd9}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_scale(input logic [4:0] v);
        @(negedge clk);
        scale_we = 1'b1;
        scale_wdata = v;
        @(negedge clk);
        scale_we = 1'b0;
    endtask

    task automatic issue(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        op = o;
        opa = a;
        opb = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
        chk("R1 result after reset", result, 64'd0);
        rst_n = 1'b1;

        // R1 scale resets to zero: 0x0100 >> 7 = 2
        issue(3'd0, 64'h0, 64'h0000_0000_0000_0100);
        chk("R1 scale zero after reset", result, 64'h2);
        chk("R2 valid one cycle after request", {63'd0, out_valid}, 64'd1);

        // R3 write in the same cycle as a request: old scale used
        @(negedge clk);
        scale_we = 1'b1;
        scale_wdata = 5'd5;
        in_valid = 1'b1;
        op = 3'd0;
        opa = '0;
        opb = 64'h0100;
        @(negedge clk);
        scale_we = 1'b0;
        in_valid = 1'b0;
        chk("R3 concurrent op uses old scale", result, 64'h2);
        issue(3'd0, 64'h0, 64'h0100);
        chk("R3 next op uses new scale", result, 64'h40);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            write_scale(VECS[i].sc);
            issue(VECS[i].op, VECS[i].a, VECS[i].b);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].e);
            if (VECS[i].op == 3'd0 || VECS[i].op == 3'd2)
                chk($sformatf("R10 upper zero vector %0d", i), {32'd0, result[63:32]}, 64'd0);
        end
        chk("R9 valid on unused op", {63'd0, out_valid}, 64'd1);

        // R2 back-to-back requests
        @(negedge clk);
        in_valid = 1'b1;
        op = 3'd3;
        opa = '0;
        opb = 64'h1;
        @(negedge clk);
        op = 3'd4;
        chk("R2 first of pair", result, 64'h10);
        chk("R2 valid during pair", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 second of pair", result, 64'h1);
        @(negedge clk);
        chk("R2 valid drops when idle", {63'd0, out_valid}, 64'd0);
        chk("R2 result held when idle", result, 64'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule